// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block drives memory reads for one overlay window of a display pipeline. Software programs a window rectangle on screen and a frame buffer region in memory through a small register write port. As the raster scan advances, the block reports whether the current pixel falls inside the rectangle. At the start of each scan line inside the window it emits a series of read bursts that cover one line of window pixels.

Each line reads a fixed number of bytes, the page width. The line address then moves past a separate skip amount, which covers the part of the frame buffer line that is not shown. Burst length follows the pixel depth. A frame start strobe rewinds the line address to the buffer start. A buffer end address stops fetching once it is reached.

The sequencer is a two-state machine. In `ST_IDLE` it waits for a line start. The transition *launch* (`ST_IDLE`→`ST_REQ`) fires on a line start when the window is enabled, the line is inside the window rows, the line address is below the end address and the page width is non-zero. In `ST_REQ` a request is presented. The transition *next burst* (`ST_REQ`→`ST_REQ`) follows an accepted burst when words remain and the next address is below the end. The transition *line done* (`ST_REQ`→`ST_IDLE`) follows the last accepted burst or reaching the end address. The transition *abort* (any→`ST_IDLE`) is taken on frame start or while disabled. A line start seen in `ST_REQ` is ignored.

Top module: `owin_fetch_gen`

## Requirements
- R1: After reset, every register reads as zero: the window is disabled, `win_active` is low and `req_valid` is low.
- R2: Register index 1 holds one corner and index 2 the other, each with x in bits [11:0] and y in bits [27:16]. Both corners are inclusive. `win_active` is high exactly when the window is enabled and corner1.x ≤ scan_x ≤ corner2.x and corner1.y ≤ scan_y ≤ corner2.y.
- R3: Register 0 bit 0 is the window enable. While it is 0, `req_valid` stays low from the cycle after the write, `win_active` is low, and line starts neither launch fetches nor advance the line address.
- R4: Register 0 bits [3:1] are a depth code: 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp, 5=24 bpp, 6=32 bpp, 7=treated as 24 bpp. The burst cap in 32-bit words is 4 for code 0, 8 for codes 1–3 and 16 for codes 4–7. Each burst is the cap or the words left in the line, whichever is smaller, and is never zero.
- R5: Register 5 holds the page width in bytes (a multiple of 4). A launched line issues bursts whose word counts add up to page/4. Each burst address is the previous one plus 4 × the previous burst length, and the first address is the line address.
- R6: Register 6 holds the skip in bytes. Each launched line moves the line address to line address + page + skip. A line start whose scan_y is outside the window rows launches nothing and leaves the line address unchanged.
- R7: Register 3 holds the start address. A frame start reloads the line address from it and drops any pending request in the next cycle. Frame start wins over a line start in the same cycle.
- R8: Register 4 holds the end address. No request is issued at an address at or above it. A line stops early once the next burst address reaches it, and a line whose line address is at or above it launches nothing.
- R9: While `req_valid` is high and `req_ready` is low, the request keeps its address and burst length on the next cycle, unless a frame start or a register 0 write intervenes. The address advances only on a handshake.
- R10: A launch presents its first request one cycle after the line start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| scan_x | input | 12 | Current scan column |
| scan_y | input | 12 | Current scan row |
| line_start | input | 1 | One-cycle strobe at the start of a scan line |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| win_active | output | 1 | Current scan position lies inside the enabled window |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 32 | Read byte address |
| req_burst | output | 5 | Burst length in 32-bit words |

## Verification
The assertions watch every cycle for four things: a held request that changes, a burst that is zero or larger than the depth allows, a request at or past the end address, and a request surviving a frame start. The rectangle edges, the way bursts split a line for each depth code, the line-to-line address step, the effect of rows outside the window, the early stop at the end address and the silence of a disabled window depend on programmed values. Only the bench scenarios can show those, by counting and comparing the requests seen at the port.

// File: rtl/owin_pkg.sv
package owin_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } fetch_state_e;

    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_CORN_A = 3'd1;
    localparam logic [2:0] IDX_CORN_B = 3'd2;
    localparam logic [2:0] IDX_START  = 3'd3;
    localparam logic [2:0] IDX_END    = 3'd4;
    localparam logic [2:0] IDX_PAGE   = 3'd5;
    localparam logic [2:0] IDX_SKIP   = 3'd6;

    localparam int BURST_W = 5;

    function automatic logic [BURST_W-1:0] burst_cap(input logic [2:0] depth);
        logic [BURST_W-1:0] cap;
        unique case (depth)
            3'd0:                cap = 5'd4;
            3'd1, 3'd2, 3'd3:    cap = 5'd8;
            default:             cap = 5'd16;
        endcase
        return cap;
    endfunction

endpackage

// File: rtl/owin_regs.sv
module owin_regs
    import owin_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_idx,
    input  logic [31:0]   cfg_wdata,
    output logic          en,
    output logic [2:0]    depth,
    output logic [CW-1:0] ax,
    output logic [CW-1:0] ay,
    output logic [CW-1:0] bx,
    output logic [CW-1:0] by,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr,
    output logic [PW-1:0] page_bytes,
    output logic [PW-1:0] skip_bytes
);
    localparam int YLO = 16;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            depth      <= '0;
            ax         <= '0;
            ay         <= '0;
            bx         <= '0;
            by         <= '0;
            start_addr <= '0;
            end_addr   <= '0;
            page_bytes <= '0;
            skip_bytes <= '0;
        end else if (cfg_we) begin
            unique case (cfg_idx)
                IDX_CTRL: begin
                    en    <= cfg_wdata[0];
                    depth <= cfg_wdata[3:1];
                end
                IDX_CORN_A: begin
                    ax <= cfg_wdata[CW-1:0];
                    ay <= cfg_wdata[YLO+CW-1:YLO];
                end
                IDX_CORN_B: begin
                    bx <= cfg_wdata[CW-1:0];
                    by <= cfg_wdata[YLO+CW-1:YLO];
                end
                IDX_START: start_addr <= cfg_wdata[AW-1:0];
                IDX_END:   end_addr   <= cfg_wdata[AW-1:0];
                IDX_PAGE:  page_bytes <= cfg_wdata[PW-1:0];
                IDX_SKIP:  skip_bytes <= cfg_wdata[PW-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/owin_hit.sv
module owin_hit #(
    parameter int CW = 12
) (
    input  logic          en,
    input  logic [CW-1:0] ax,
    input  logic [CW-1:0] ay,
    input  logic [CW-1:0] bx,
    input  logic [CW-1:0] by,
    input  logic [CW-1:0] scan_x,
    input  logic [CW-1:0] scan_y,
    output logic          row_hit,
    output logic          pix_hit
);
    logic col_in;
    logic row_in;

    always_comb begin
        col_in  = (scan_x >= ax) && (scan_x <= bx);
        row_in  = (scan_y >= ay) && (scan_y <= by);
        row_hit = en && row_in;
        pix_hit = en && row_in && col_in;
    end

endmodule

// File: rtl/owin_fetch_fsm.sv
module owin_fetch_fsm
    import owin_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [2:0]         depth,
    input  logic               row_hit,
    input  logic               line_start,
    input  logic               frame_start,
    input  logic [AW-1:0]      start_addr,
    input  logic [AW-1:0]      end_addr,
    input  logic [PW-1:0]      page_bytes,
    input  logic [PW-1:0]      skip_bytes,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [AW-1:0]      req_addr,
    output logic [BURST_W-1:0] req_burst
);
    localparam int WW = PW - 2;

    fetch_state_e  state_q, state_d;
    logic [AW-1:0] line_q, line_d;
    logic [AW-1:0] cur_q, cur_d;
    logic [WW-1:0] rem_q, rem_d;

    logic [WW-1:0] page_words;
    logic [WW-1:0] cap_w;
    logic [WW-1:0] len_w;
    logic [AW-1:0] step_addr;
    logic [AW-1:0] line_next;
    logic          launch_ok;

    always_comb begin
        page_words = page_bytes[PW-1:2];
        cap_w      = WW'(burst_cap(depth));
        len_w      = (cap_w < rem_q) ? cap_w : rem_q;
        step_addr  = cur_q + AW'({len_w, 2'b00});
        line_next  = line_q + AW'(page_bytes) + AW'(skip_bytes);
        launch_ok  = line_start && row_hit && (line_q < end_addr) && (page_words != '0);
    end

    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        cur_d   = cur_q;
        rem_d   = rem_q;
        if (frame_start) begin
            state_d = ST_IDLE;
            line_d  = start_addr;
        end else if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch_ok) begin
                        state_d = ST_REQ;
                        cur_d   = line_q;
                        rem_d   = page_words;
                        line_d  = line_next;
                    end
                end
                ST_REQ: begin
                    if (req_ready) begin
                        cur_d = step_addr;
                        rem_d = rem_q - len_w;
                        if ((rem_q == len_w) || (step_addr >= end_addr)) begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            cur_q   <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            cur_q   <= cur_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        req_valid = (state_q == ST_REQ) && en;
        req_addr  = cur_q;
        req_burst = BURST_W'(len_w);
    end

    AST_NO_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $stable(end_addr)) |-> (req_addr < end_addr)) // R8
        else $error("request at or beyond end address");

    AST_FRAME_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !req_valid) // R7
        else $error("request survived frame start");

    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_burst != '0) && (req_burst <= burst_cap(depth)))) // R4
        else $error("burst length out of range");

endmodule

// File: rtl/owin_fetch_gen.sv
module owin_fetch_gen
    import owin_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12,
    parameter int PW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_idx,
    input  logic [31:0]        cfg_wdata,
    input  logic [CW-1:0]      scan_x,
    input  logic [CW-1:0]      scan_y,
    input  logic               line_start,
    input  logic               frame_start,
    output logic               win_active,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [AW-1:0]      req_addr,
    output logic [BURST_W-1:0] req_burst
);
    logic          en;
    logic [2:0]    depth;
    logic [CW-1:0] ax, ay, bx, by;
    logic [AW-1:0] start_addr, end_addr;
    logic [PW-1:0] page_bytes, skip_bytes;
    logic          row_hit;

    owin_regs #(.AW(AW), .CW(CW), .PW(PW)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .en         (en),
        .depth      (depth),
        .ax         (ax),
        .ay         (ay),
        .bx         (bx),
        .by         (by),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .page_bytes (page_bytes),
        .skip_bytes (skip_bytes)
    );

    owin_hit #(.CW(CW)) i_hit (
        .en      (en),
        .ax      (ax),
        .ay      (ay),
        .bx      (bx),
        .by      (by),
        .scan_x  (scan_x),
        .scan_y  (scan_y),
        .row_hit (row_hit),
        .pix_hit (win_active)
    );

    owin_fetch_fsm #(.AW(AW), .PW(PW)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .depth       (depth),
        .row_hit     (row_hit),
        .line_start  (line_start),
        .frame_start (frame_start),
        .start_addr  (start_addr),
        .end_addr    (end_addr),
        .page_bytes  (page_bytes),
        .skip_bytes  (skip_bytes),
        .req_ready   (req_ready),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_burst   (req_burst)
    );

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !frame_start && !(cfg_we && cfg_idx == IDX_CTRL))
        |=> (req_valid && $stable(req_addr) && $stable(req_burst))) // R9
        else $error("request changed while stalled");

endmodule

// File: tb/test_owin_fetch_gen.sv
module test_owin_fetch_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [11:0] scan_x = '0;
    logic [11:0] scan_y = '0;
    logic        line_start = 1'b0;
    logic        frame_start = 1'b0;
    logic        win_active;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [4:0]  req_burst;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // {depth[35:32], page bytes[31:20], burst count[19:16], cap words[15:8], last burst[7:0]}
    localparam logic [35:0] VEC [8] = '{
        {4'd0, 12'd40,  4'd3, 8'd4,  8'd2},
        {4'd1, 12'd64,  4'd2, 8'd8,  8'd8},
        {4'd3, 12'd12,  4'd1, 8'd8,  8'd3},
        {4'd4, 12'd128, 4'd2, 8'd16, 8'd16},
        {4'd5, 12'd100, 4'd2, 8'd16, 8'd9},
        {4'd6, 12'd4,   4'd1, 8'd16, 8'd1},
        {4'd7, 12'd68,  4'd2, 8'd16, 8'd1},
        {4'd2, 12'd36,  4'd2, 8'd8,  8'd1}
    };

    owin_fetch_gen i_owin_fetch_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_idx     (cfg_idx),
        .cfg_wdata   (cfg_wdata),
        .scan_x      (scan_x),
        .scan_y      (scan_y),
        .line_start  (line_start),
        .frame_start (frame_start),
        .win_active  (win_active),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_burst   (req_burst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic pulse_line(input logic [11:0] y);
        @(negedge clk);
        scan_y = y; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic collect(input int cycles, output int cnt, output logic [31:0] first_addr,
                           output int first_burst, output int last_burst, output int words,
                           output int step_err);
        logic [31:0] exp_addr;
        cnt = 0; first_addr = '0; first_burst = 0; last_burst = 0; words = 0; step_err = 0;
        exp_addr = '0;
        req_ready = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            if (req_valid) begin
                if (cnt == 0) begin
                    first_addr  = req_addr;
                    first_burst = int'(req_burst);
                end else if (req_addr != exp_addr) begin
                    step_err++;
                end
                exp_addr   = req_addr + 32'(req_burst) * 4;
                last_burst = int'(req_burst);
                words      = words + int'(req_burst);
                cnt++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt, fb, lb, words, serr;
        logic [31:0] fa;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        scan_x = 12'd0; scan_y = 12'd0;
        #1;
        chk(req_valid == 1'b0, "R1 valid after reset", req_valid, 0);
        chk(win_active == 1'b0, "R1 window inactive after reset", win_active, 0);

        // common setup for the vector walk
        wr(3'd1, {4'd0, 12'd0, 4'd0, 12'd0});
        wr(3'd2, {4'd0, 12'd479, 4'd0, 12'd639});
        wr(3'd3, 32'h0000_4000);
        wr(3'd4, 32'h0010_0000);
        wr(3'd6, 32'd0);

        // R4 R5 R10: burst split per depth code
        for (int v = 0; v < 8; v++) begin
            int page, wcount, cap, expf;
            page   = int'(VEC[v][31:20]);
            wcount = page / 4;
            cap    = int'(VEC[v][15:8]);
            expf   = (wcount < cap) ? wcount : cap;
            wr(3'd0, {28'd0, VEC[v][34:32], 1'b1});
            wr(3'd5, {20'd0, VEC[v][31:20]});
            pulse_frame();
            pulse_line(12'd5);
            collect(30, cnt, fa, fb, lb, words, serr);
            chk(cnt == int'(VEC[v][19:16]), "R4 burst count", cnt, VEC[v][19:16]);
            chk(fb == expf, "R4 first burst length", fb, expf);
            chk(lb == int'(VEC[v][7:0]), "R4 last burst length", lb, VEC[v][7:0]);
            chk(words == wcount, "R5 words per line", words, wcount);
            chk(serr == 0, "R5 address step", serr, 0);
            chk(fa == 32'h4000, "R5 R10 first line address", fa, 32'h4000);
        end

        // R2: inclusive rectangle (10,20)-(19,29)
        wr(3'd1, {4'd0, 12'd20, 4'd0, 12'd10});
        wr(3'd2, {4'd0, 12'd29, 4'd0, 12'd19});
        wr(3'd0, {28'd0, 3'd3, 1'b1});
        @(negedge clk); scan_x = 12'd9;  scan_y = 12'd20; #1;
        chk(win_active == 1'b0, "R2 left of window", win_active, 0);
        @(negedge clk); scan_x = 12'd10; scan_y = 12'd20; #1;
        chk(win_active == 1'b1, "R2 top-left corner", win_active, 1);
        @(negedge clk); scan_x = 12'd19; scan_y = 12'd29; #1;
        chk(win_active == 1'b1, "R2 bottom-right corner", win_active, 1);
        @(negedge clk); scan_x = 12'd20; scan_y = 12'd25; #1;
        chk(win_active == 1'b0, "R2 right of window", win_active, 0);
        @(negedge clk); scan_x = 12'd15; scan_y = 12'd30; #1;
        chk(win_active == 1'b0, "R2 below window", win_active, 0);
        @(negedge clk); scan_x = 12'd15; scan_y = 12'd19; #1;
        chk(win_active == 1'b0, "R2 above window", win_active, 0);

        // R6 R8: line stepping with skip, bounded by end address
        wr(3'd3, 32'h0000_1000);
        wr(3'd4, 32'h0000_1090);
        wr(3'd5, 32'd32);
        wr(3'd6, 32'd16);
        pulse_frame();
        pulse_line(12'd19);
        collect(6, cnt, fa, fb, lb, words, serr);
        chk(cnt == 0, "R6 row above window fetches nothing", cnt, 0);
        pulse_line(12'd20);
        collect(6, cnt, fa, fb, lb, words, serr);
        chk(fa == 32'h1000 && cnt == 1, "R6 first line address", fa, 32'h1000);
        pulse_line(12'd21);
        collect(6, cnt, fa, fb, lb, words, serr);
        chk(fa == 32'h1030, "R6 second line address", fa, 32'h1030);
        pulse_line(12'd22);
        collect(6, cnt, fa, fb, lb, words, serr);
        chk(fa == 32'h1060, "R6 third line address", fa, 32'h1060);
        pulse_line(12'd23);
        collect(6, cnt, fa, fb, lb, words, serr);
        chk(cnt == 0, "R8 line at end address fetches nothing", cnt, 0);

        // R7: frame start reloads start address
        pulse_frame();
        pulse_line(12'd24);
        collect(6, cnt, fa, fb, lb, words, serr);
        chk(fa == 32'h1000 && cnt == 1, "R7 reload after frame start", fa, 32'h1000);

        // R9: stall holds request
        req_ready = 1'b0;
        pulse_line(12'd25);
        chk(req_valid == 1'b1, "R10 request one cycle after line start", req_valid, 1);
        chk(req_addr == 32'h1030, "R9 stalled request address", req_addr, 32'h1030);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(req_valid && req_addr == 32'h1030 && req_burst == 5'd8,
                "R9 request held while not ready", req_addr, 32'h1030);
        end
        req_ready = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R9 request retired after handshake", req_valid, 0);

        // R7: frame start drops a pending request
        req_ready = 1'b0;
        pulse_line(12'd26);
        chk(req_valid == 1'b1 && req_addr == 32'h1060, "R7 pending request present", req_addr, 32'h1060);
        pulse_frame();
        chk(req_valid == 1'b0, "R7 pending request dropped", req_valid, 1'b0);
        pulse_line(12'd27);
        collect(6, cnt, fa, fb, lb, words, serr);
        chk(fa == 32'h1000, "R7 next line after drop from start", fa, 32'h1000);

        // R8: end address reached mid-line
        wr(3'd0, {28'd0, 3'd0, 1'b1});
        wr(3'd3, 32'h0000_2000);
        wr(3'd4, 32'h0000_2020);
        wr(3'd5, 32'd64);
        pulse_frame();
        pulse_line(12'd20);
        collect(10, cnt, fa, fb, lb, words, serr);
        chk(cnt == 2, "R8 line stops at end address", cnt, 2);
        chk(words == 8, "R8 words before end", words, 8);

        // R3: disabled window issues nothing and does not advance
        wr(3'd4, 32'h0010_0000);
        pulse_frame();
        wr(3'd0, {28'd0, 3'd0, 1'b0});
        scan_x = 12'd12;
        pulse_line(12'd21);
        chk(win_active == 1'b0, "R3 window inactive when disabled", win_active, 0);
        collect(8, cnt, fa, fb, lb, words, serr);
        chk(cnt == 0, "R3 no requests when disabled", cnt, 0);
        wr(3'd0, {28'd0, 3'd0, 1'b1});
        pulse_line(12'd22);
        collect(10, cnt, fa, fb, lb, words, serr);
        chk(fa == 32'h2000, "R3 disabled line did not advance address", fa, 32'h2000);

        // R3: disable during a stalled request
        req_ready = 1'b0;
        pulse_line(12'd23);
        chk(req_valid == 1'b1, "R3 request before disable", req_valid, 1);
        wr(3'd0, {28'd0, 3'd0, 1'b0});
        chk(req_valid == 1'b0, "R3 request withdrawn after disable", req_valid, 0);
        req_ready = 1'b1;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule